// File: doc/BRIEF.md
# I2C Single-Message Transfer Sequencer

This block runs one whole I2C write or read of one to eight bytes with no software action between bytes. Software first places the outgoing payload in two 32-bit transmit words. It then writes one control word that carries the target address, the address width, the direction, the byte count and a launch bit. From there the sequencer works on its own. It drives a lower-level byte engine through a command/done handshake and steps through START, one or two address bytes, the data bytes and STOP.

When STOP finishes, received bytes sit little-endian in two 32-bit receive words. A status bit records whether any acknowledge was missing. Two interrupt cause bits record the completion, and the interrupt output is raised for every cause bit whose mask bit is set. Software acknowledges the completion by writing zero to the cause register.

The byte engine takes one command at a time: START, WRITE (send `cmd_byte` and report the acknowledge), READ (receive a byte, then ACK it, or NACK it when `cmd_last` is high) and STOP. It pulses `cmd_done` once for each command.

Top module: `i2c_msg_offload`

## Requirements
- R1: After reset every register reads zero, `cmd_valid` is low and `irq` is low. Register addresses: 0 control, 1 status, 2 cause, 3 mask, 4 transmit low, 5 transmit high, 6 receive low, 7 receive high.
- R2: A control write launches a transfer only when the sequencer is idle, control bit 19 is set and exactly one of bit 0 (write) or bit 1 (read) is set. Any other control word is stored but issues no command. The first command of a transfer is START (op code 0), and the last is STOP (op code 3).
- R3: The target address is taken from control bits [11:2]. In 7-bit mode (bit 12 clear) one address byte is sent, holding bits [8:2] in its upper seven bits and the read flag in its bit 0. In 10-bit mode (bit 12 set) the first byte is 11110, then address bits 9:8, then the read flag, and the second byte is address bits 7:0. Address bytes use the WRITE op code 1.
- R4: A write sends (control bits [15:13]) + 1 data bytes. Byte k is taken little-endian from the 64-bit value {transmit high, transmit low}, so byte 0 is transmit low bits [7:0] and byte 4 is transmit high bits [7:0].
- R5: A read issues (control bits [18:16]) + 1 READ commands (op code 2). `cmd_last` is high only on the final one. Byte k is stored little-endian into {receive high, receive low}, and byte positions that are not received read as zero because both receive words are cleared at launch.
- R6: A missing acknowledge on any address byte or write data byte ends the transfer: the next command is STOP, no further byte is sent, and status bit 0 becomes 1.
- R7: When STOP completes, cause bit 0 becomes 1, cause bit 1 takes the error result, and status bit 0 is set on error or cleared on success.
- R8: `irq` equals the OR of (cause[1:0] AND mask[1:0]). A write to the cause register loads bits [1:0], so writing zero clears it.
- R9: While a transfer is running, writes to the control, transmit low and transmit high registers are ignored.
- R10: `cmd_valid` stays high with `cmd_op`, `cmd_byte` and `cmd_last` stable until `cmd_done`, and each `cmd_done` completes exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_valid | output | 1 | Byte-engine command pending |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_byte | output | 8 | Byte to send on WRITE |
| cmd_last | output | 1 | NACK the byte of this READ |
| cmd_done | input | 1 | Byte engine finished the current command |
| rsp_ack | input | 1 | Acknowledge received on WRITE |
| rsp_byte | input | 8 | Byte received on READ |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the sequencer with its default register address width of three bits. With that width, all eight registers can be reached and every encoding of the control word can be used, including 10-bit addresses and both ends of the one-to-eight byte range. A byte-engine model with a chosen response delay answers each command. This lets the bench inject a missing acknowledge at a chosen address or data position, and lets it issue register writes while a transfer is in flight.

// File: rtl/i2c_msg_offload.sv
module i2c_msg_offload #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_last,
  input  logic          cmd_done,
  input  logic          rsp_ack,
  input  logic [7:0]    rsp_byte,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_STAT = AW'(1), A_CAUSE = AW'(2), A_MASK = AW'(3);
  localparam logic [AW-1:0] A_TXL = AW'(4), A_TXH = AW'(5), A_RXL = AW'(6), A_RXH = AW'(7);
  localparam int B_WR = 0, B_RD = 1, B_EXT = 12, B_TXN = 13, B_RXN = 16, B_GO = 19;
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADR1, S_ADR2, S_DATA, S_STOP} st_t;
  st_t state;

  logic [31:0] ctrl_q, tx_lo, tx_hi;
  logic [63:0] rx_q;
  logic [1:0]  cause_q, mask_q;
  logic        err_q, err_run, rd_m, ten_m;
  logic [9:0]  adr_m;
  logic [2:0]  len_m, cnt;

  wire idle   = (state == S_IDLE);
  wire at_end = (cnt == len_m);
  wire launch = reg_we && reg_addr == A_CTRL && idle && reg_wdata[B_GO] &&
                (reg_wdata[B_WR] ^ reg_wdata[B_RD]);
  wire fin    = (state == S_STOP) && cmd_done;
  wire [63:0] tx_w = {tx_hi, tx_lo};
  wire [7:0]  adr1 = ten_m ? {5'b11110, adr_m[9:8], rd_m} : {adr_m[6:0], rd_m};

  assign cmd_valid = !idle;
  assign cmd_last  = (state == S_DATA) && rd_m && at_end;
  assign irq       = |(cause_q & mask_q);

  always_comb begin
    cmd_op   = OP_WRITE;
    cmd_byte = 8'h00;
    case (state)
      S_START: cmd_op = OP_START;
      S_ADR1:  cmd_byte = adr1;
      S_ADR2:  cmd_byte = adr_m[7:0];
      S_DATA:  if (rd_m) cmd_op = OP_READ; else cmd_byte = tx_w[cnt*8 +: 8];
      S_STOP:  cmd_op = OP_STOP;
      default: cmd_op = OP_START;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {31'd0, err_q};
      A_CAUSE: reg_rdata = {30'd0, cause_q};
      A_MASK:  reg_rdata = {30'd0, mask_q};
      A_TXL:   reg_rdata = tx_lo;
      A_TXH:   reg_rdata = tx_hi;
      A_RXL:   reg_rdata = rx_q[31:0];
      A_RXH:   reg_rdata = rx_q[63:32];
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ctrl_q <= '0; tx_lo <= '0; tx_hi <= '0; rx_q <= '0;
      cause_q <= '0; mask_q <= '0; err_q <= 1'b0; err_run <= 1'b0;
      rd_m <= 1'b0; ten_m <= 1'b0; adr_m <= '0; len_m <= '0; cnt <= '0;
    end else begin
      if (reg_we && idle) begin
        if (reg_addr == A_CTRL) ctrl_q <= reg_wdata;
        if (reg_addr == A_TXL)  tx_lo  <= reg_wdata;
        if (reg_addr == A_TXH)  tx_hi  <= reg_wdata;
      end
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[1:0];
      if (fin) begin
        cause_q <= {err_run, 1'b1};
        err_q   <= err_run;
      end else if (reg_we && reg_addr == A_CAUSE) begin
        cause_q <= reg_wdata[1:0];
      end
      if (launch) begin
        state   <= S_START;
        rd_m    <= reg_wdata[B_RD];
        ten_m   <= reg_wdata[B_EXT];
        adr_m   <= reg_wdata[11:2];
        len_m   <= reg_wdata[B_RD] ? reg_wdata[B_RXN +: 3] : reg_wdata[B_TXN +: 3];
        cnt     <= '0;
        err_run <= 1'b0;
        rx_q    <= '0;
      end else if (cmd_done) begin
        case (state)
          S_START: state <= S_ADR1;
          S_ADR1: begin
            if (!rsp_ack) begin err_run <= 1'b1; state <= S_STOP; end
            else state <= ten_m ? S_ADR2 : S_DATA;
          end
          S_ADR2: begin
            if (!rsp_ack) begin err_run <= 1'b1; state <= S_STOP; end
            else state <= S_DATA;
          end
          S_DATA: begin
            if (rd_m) begin
              rx_q[cnt*8 +: 8] <= rsp_byte;
              if (at_end) state <= S_STOP; else cnt <= cnt + 3'd1;
            end else if (!rsp_ack) begin
              err_run <= 1'b1; state <= S_STOP;
            end else if (at_end) state <= S_STOP;
            else cnt <= cnt + 3'd1;
          end
          S_STOP:  state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_msg_offload_chk.sv
module i2c_msg_offload_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_byte,
  input logic          cmd_last,
  input logic          cmd_done,
  input logic          rsp_ack,
  input logic          irq,
  input logic [1:0]    cause_q,
  input logic [31:0]   ctrl_q
);
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_last));

  assert_first_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> cmd_op == 2'd0);

  assert_last_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_last |-> cmd_valid && cmd_op == 2'd2);

  assert_nack_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done && cmd_op == 2'd1 && !rsp_ack |=> cmd_valid && cmd_op == 2'd3);

  assert_finish_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done && cmd_op == 2'd3 |=> cause_q[0] && !cmd_valid);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(reg_we && (reg_addr == AW'(2) || reg_addr == AW'(3))) ||
                   $past(cmd_valid && cmd_done && cmd_op == 2'd3));

  assert_busy_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && reg_we && reg_addr == AW'(0) |=> $stable(ctrl_q));
endmodule

bind i2c_msg_offload i2c_msg_offload_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
  .cmd_done(cmd_done), .rsp_ack(rsp_ack), .irq(irq), .cause_q(cause_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_i2c_msg_offload.sv
module tb_i2c_msg_offload;
  localparam int AW = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_last, irq;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic cmd_done = 1'b0, rsp_ack = 1'b0;
  logic [7:0] rsp_byte = '0;

  i2c_msg_offload #(.AW(AW)) dut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  string cur_req = "R2";
  logic [10:0] exp_q[$];
  int ev_cnt = 0, nack_idx = -1, rd_k = 0;
  logic [63:0] rd_src = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = AW'(a); #1 d = reg_rdata;
  endtask

  // Byte-engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        logic [10:0] got, e;
        int idx;
        got = {cmd_op, cmd_byte, cmd_last};
        idx = ev_cnt; ev_cnt++;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected command act=%h exp=none", cur_req, got);
        end else begin
          e = exp_q.pop_front();
          if (got !== e) begin
            fails++;
            $display("FAIL %s command %0d act=%h exp=%h", cur_req, idx, got, e);
          end
        end
        repeat (2) @(negedge clk);
        chk("R10", {cmd_valid, cmd_op, cmd_byte, cmd_last}, {1'b1, got});
        rsp_ack = (idx != nack_idx);
        rsp_byte = 8'h00;
        if (cmd_op == 2'd2) begin rsp_byte = rd_src[rd_k*8 +: 8]; rd_k++; end
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
      end
    end
  end

  task automatic xfer(input bit rdn, input bit ten, input int adr, input int len,
                      input logic [63:0] data, input int nack_at, input string req);
    logic [31:0] c, v;
    logic [63:0] rx_exp;
    int e;
    bit err;
    cur_req = req; ev_cnt = 0; nack_idx = nack_at; rd_k = 0; rd_src = data; err = 0;
    exp_q.push_back({2'd0, 8'h00, 1'b0});
    e = 1;
    if (ten) exp_q.push_back({2'd1, 5'b11110, 2'(adr >> 8), rdn, 1'b0});
    else     exp_q.push_back({2'd1, 7'(adr), rdn, 1'b0});
    if (nack_at == e) err = 1;
    e++;
    if (ten && !err) begin
      exp_q.push_back({2'd1, 8'(adr), 1'b0});
      if (nack_at == e) err = 1;
      e++;
    end
    for (int k = 0; k < len && !err; k++) begin
      if (rdn) exp_q.push_back({2'd2, 8'h00, k == len - 1});
      else begin
        exp_q.push_back({2'd1, data[k*8 +: 8], 1'b0});
        if (nack_at == e) err = 1;
      end
      e++;
    end
    exp_q.push_back({2'd3, 8'h00, 1'b0});
    if (!rdn) begin wr(4, data[31:0]); wr(5, data[63:32]); end
    c = 32'h0008_0000 | (rdn ? 32'd2 : 32'd1) | (32'(adr) << 2) | (32'(ten) << 12) |
        (32'(len - 1) << (rdn ? 16 : 13));
    wr(0, c);
    for (int t = 0; t < 3000; t++) begin rd(2, v); if (v[0]) break; end
    chk({req, "/R7 cause"}, 64'(v), {62'd0, err, 1'b1});
    chk({req, "/R2 all commands issued"}, 64'(exp_q.size()), 64'd0);
    rd(1, v); chk({req, "/R6/R7 status"}, 64'(v), 64'(err));
    if (rdn) begin
      rx_exp = '0;
      for (int k = 0; k < len; k++) rx_exp[k*8 +: 8] = data[k*8 +: 8];
      rd(6, v); chk({req, "/R5 rx low"}, 64'(v), 64'(rx_exp[31:0]));
      rd(7, v); chk({req, "/R5 rx high"}, 64'(v), 64'(rx_exp[63:32]));
    end
    wr(2, 0);
    exp_q.delete();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 reg reset", 64'(v), 64'd0); end
    chk("R1 outputs", {cmd_valid, irq}, 2'b00);

    xfer(0, 0, 7'h50, 1, 64'h0000_0000_0000_00A5, -1, "R3 7-bit write");
    xfer(0, 0, 7'h1D, 8, 64'h8877_6655_4433_2211, -1, "R4 write 8");
    xfer(0, 1, 10'h2B7, 3, 64'h0000_0000_00C3_B2A1, -1, "R3 10-bit write");
    xfer(1, 0, 7'h6A, 1, 64'h0000_0000_0000_005E, -1, "R5 read 1");
    xfer(1, 1, 10'h15C, 8, 64'hF1E2_D3C4_B5A6_9788, -1, "R5 10-bit read 8");
    xfer(1, 0, 7'h22, 5, 64'h1234_5678_9ABC_DEF0, -1, "R5 read 5");
    xfer(0, 0, 7'h33, 4, 64'h0000_0000_0403_0201, 1, "R6 addr nack");
    xfer(0, 0, 7'h34, 6, 64'h0000_6655_4433_2211, 4, "R6 data nack");
    xfer(0, 1, 10'h301, 2, 64'h0000_0000_0000_BBAA, 2, "R6 10-bit addr2 nack");
    xfer(0, 0, 7'h35, 2, 64'h0000_0000_0000_7766, -1, "R7 success clears error");

    // R8 interrupt masking
    wr(3, 0);
    xfer(0, 0, 7'h40, 1, 64'h11, -1, "R8 prep");
    wr(2, 32'h1); chk("R8 masked irq", 64'(irq), 64'd0);
    wr(3, 32'h1); chk("R8 unmasked irq", 64'(irq), 64'd1);
    wr(2, 32'h2); chk("R8 cause1 mask1", 64'(irq), 64'd0);
    wr(3, 32'h2); chk("R8 cause1 mask2", 64'(irq), 64'd1);
    wr(2, 0);     chk("R8 clear cause", 64'(irq), 64'd0);
    wr(3, 0);

    // R9 writes while busy
    cur_req = "R9 busy"; ev_cnt = 0; nack_idx = -1; rd_k = 0;
    wr(4, 32'h4433_2211); wr(5, 32'h8877_6655);
    exp_q.push_back({2'd0, 8'h00, 1'b0});
    exp_q.push_back({2'd1, 7'h2C, 1'b0, 1'b0});
    for (int k = 0; k < 8; k++) exp_q.push_back({2'd1, 8'(8'h11 * (k + 1)), 1'b0});
    exp_q.push_back({2'd3, 8'h00, 1'b0});
    wr(0, 32'h0008_E000 | (32'h2C << 2) | 32'd1);
    repeat (3) @(negedge clk);
    wr(0, 32'h0009_0006);
    wr(4, 32'hDEAD_BEEF);
    for (int t = 0; t < 3000; t++) begin rd(2, v); if (v[0]) break; end
    chk("R9 done", 64'(v), 64'd1);
    chk("R9 sequence unchanged", 64'(exp_q.size()), 64'd0);
    rd(0, v); chk("R9 ctrl kept", 64'(v), 64'(32'h0008_E000 | (32'h2C << 2) | 32'd1));
    rd(4, v); chk("R9 tx kept", 64'(v), 64'h4433_2211);
    wr(2, 0);
    repeat (20) @(negedge clk);

    // R2 invalid launch words
    foreach (v[i]) ;
    cur_req = "R2 no launch";
    wr(0, 32'h0008_0003);
    nv = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); if (cmd_valid) nv++; end
    chk("R2 both dirs no launch", 64'(nv), 64'd0);
    rd(0, v); chk("R2 ctrl stored", 64'(v), 64'h0008_0003);
    wr(0, 32'h0000_0001);
    nv = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); if (cmd_valid) nv++; end
    chk("R2 no enable no launch", 64'(nv), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule